// File: doc/BRIEF.md
# Packed Decimal Byte Adder

This unit adds two packed BCD bytes together with an incoming extend bit. Each byte holds two decimal digits. The result is a packed BCD byte plus a fresh set of condition flags. The caller pulses `start` with the operands and the current extend and zero flags applied. One clock later the registered result and flags appear, together with a single-cycle `done`.

Multi-digit decimal numbers are added one byte at a time, starting with the least significant byte. The caller feeds the returned extend flag back in as the carry for the next byte. It also feeds back the returned zero flag. The zero flag can only be cleared by a non-zero byte and is never set by a zero byte. After software presets it to 1 before the first byte, it therefore reports whether the whole multi-byte result was zero.

The digit count is a parameter with a default of two digits, one byte. Each digit has its own correction cell, and the carry ripples from the low digit to the high digit.

Top module: `dec_byte_adder`

## Requirements
- R1: The low result digit (bits 3:0) is formed from the binary sum of the source low nibble, the destination low nibble and `ext_in`. When that sum exceeds 9, 6 is added, the value is kept modulo 16, and a carry of 1 passes into the high digit.
- R2: The high result digit (bits 7:4) is formed by the same rule from the two high nibbles plus the carry from the low digit.
- R3: `carry_out` is 1 exactly when the high digit's binary sum (including its incoming carry) exceeds 9, and 0 otherwise.
- R4: `ext_out` always equals `carry_out` after an operation.
- R5: `zero_out` is 0 when the result byte is non-zero. When the result byte is 0x00, `zero_out` takes the value of `zero_in`, so a zero byte never sets it.
- R6: `neg_out` equals bit 7 of the result and `ovf_out` is 0. These flags carry no arithmetic meaning, but their values are fixed.
- R7: `done` is 1 in the cycle after a cycle with `start` high and 0 in the cycle after a cycle with `start` low.
- R8: In any cycle without `start`, the result and all flags keep their previous values.
- R9: After reset, `sum_out` is 0x00, every flag is 0 and `done` is 0.
- R10: Nibbles A to F are processed by the same rule with no special case. For example, 0xFF + 0xFF + 1 gives 0x55 with `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one addition |
| src_byte | input | 8 | Source packed BCD operand |
| dst_byte | input | 8 | Destination packed BCD operand |
| ext_in | input | 1 | Incoming extend (decimal carry-in) |
| zero_in | input | 1 | Incoming zero flag |
| sum_out | output | 8 | Packed BCD result |
| ext_out | output | 1 | New extend flag |
| neg_out | output | 1 | New negative flag (result MSB) |
| zero_out | output | 1 | New zero flag (sticky clear) |
| ovf_out | output | 1 | New overflow flag (always 0) |
| carry_out | output | 1 | New decimal carry |
| done | output | 1 | Result valid pulse |

## Verification
Directed cases cover several distinct behaviours:
- Sums with no correction (12+34).
- A correction in only the low digit (08+05), which separates the inter-digit carry from the high-digit correction.
- A full decimal wrap (99+00+1), which shows the decimal carry and a zero result with the zero flag both preset and clear.
- Non-decimal nibbles (FF+FF+1), which pin down the deterministic correction.

Random operands follow, with `start` sometimes held low, which separates the holding behaviour from fresh updates. A behavioural integer model is compared against every output on every cycle.

// File: rtl/dec_adder_pkg.sv
package dec_adder_pkg;
   localparam int DIGIT_W   = 4;
   localparam int DIGIT_MAX = 9;
   localparam int DIGIT_FIX = 6;

   typedef struct packed {
      logic ext;
      logic neg;
      logic zero;
      logic ovf;
      logic carry;
   } dec_flags_t;
endpackage

// File: rtl/dec_digit_cell.sv
module dec_digit_cell
   import dec_adder_pkg::*;
(
   input  logic [DIGIT_W-1:0] a_dig,
   input  logic [DIGIT_W-1:0] b_dig,
   input  logic               c_in,
   output logic [DIGIT_W-1:0] r_dig,
   output logic               c_out
);
   localparam int RAW_W = DIGIT_W + 1;

   logic [RAW_W-1:0] raw_sum;
   logic [RAW_W-1:0] fixed_sum;

   always_comb begin
      raw_sum   = RAW_W'(a_dig) + RAW_W'(b_dig) + RAW_W'(c_in);
      c_out     = (raw_sum > RAW_W'(DIGIT_MAX));
      fixed_sum = raw_sum + (c_out ? RAW_W'(DIGIT_FIX) : RAW_W'(0));
      r_dig     = fixed_sum[DIGIT_W-1:0];
   end
endmodule

// File: rtl/dec_digit_chain.sv
module dec_digit_chain
   import dec_adder_pkg::*;
#(
   parameter int NUM_DIGITS = 2,
   localparam int DATA_W = NUM_DIGITS * DIGIT_W
)
(
   input  logic [DATA_W-1:0] a_val,
   input  logic [DATA_W-1:0] b_val,
   input  logic              c_in,
   output logic [DATA_W-1:0] r_val,
   output logic              c_out
);
   logic [NUM_DIGITS:0] carry_link;

   assign carry_link[0] = c_in;

   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
      dec_digit_cell u_cell (
         .a_dig (a_val[g*DIGIT_W +: DIGIT_W]),
         .b_dig (b_val[g*DIGIT_W +: DIGIT_W]),
         .c_in  (carry_link[g]),
         .r_dig (r_val[g*DIGIT_W +: DIGIT_W]),
         .c_out (carry_link[g+1])
      );
   end

   assign c_out = carry_link[NUM_DIGITS];
endmodule

// File: rtl/dec_flag_gen.sv
module dec_flag_gen
   import dec_adder_pkg::*;
#(
   parameter int DATA_W = 8
)
(
   input  logic [DATA_W-1:0] result,
   input  logic              dec_carry,
   input  logic              zero_prev,
   output dec_flags_t        flags
);
   always_comb begin
      flags.carry = dec_carry;
      flags.ext   = dec_carry;
      flags.neg   = result[DATA_W-1];
      flags.ovf   = 1'b0;
      flags.zero  = (result == '0) ? zero_prev : 1'b0;
   end
endmodule

// File: rtl/dec_byte_adder.sv
module dec_byte_adder
   import dec_adder_pkg::*;
#(
   parameter int NUM_DIGITS = 2,
   localparam int DATA_W = NUM_DIGITS * DIGIT_W
)
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] src_byte,
   input  logic [DATA_W-1:0] dst_byte,
   input  logic              ext_in,
   input  logic              zero_in,
   output logic [DATA_W-1:0] sum_out,
   output logic              ext_out,
   output logic              neg_out,
   output logic              zero_out,
   output logic              ovf_out,
   output logic              carry_out,
   output logic              done
);
   initial begin
      if (NUM_DIGITS < 1) $error("NUM_DIGITS must be at least 1");
   end

   logic [DATA_W-1:0] comb_sum;
   logic              comb_carry;
   dec_flags_t        comb_flags;
   dec_flags_t        flag_q;
   logic [DATA_W-1:0] sum_q;
   logic              done_q;

   dec_digit_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
      .a_val (src_byte),
      .b_val (dst_byte),
      .c_in  (ext_in),
      .r_val (comb_sum),
      .c_out (comb_carry)
   );

   dec_flag_gen #(.DATA_W(DATA_W)) u_flags (
      .result    (comb_sum),
      .dec_carry (comb_carry),
      .zero_prev (zero_in),
      .flags     (comb_flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q  <= '0;
         flag_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= start;
         if (start) begin
            sum_q  <= comb_sum;
            flag_q <= comb_flags;
         end
      end
   end

   assign sum_out   = sum_q;
   assign ext_out   = flag_q.ext;
   assign neg_out   = flag_q.neg;
   assign zero_out  = flag_q.zero;
   assign ovf_out   = flag_q.ovf;
   assign carry_out = flag_q.carry;
   assign done      = done_q;

   AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done); // R7
   AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done); // R7
   AST_EXT_MATCH_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ext_out == carry_out)); // R4
   AST_ZERO_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !zero_in) |=> !zero_out); // R5
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(sum_out) && $stable(carry_out) && $stable(zero_out))); // R8
   AST_OVF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ovf_out); // R6
endmodule

// File: tb/dec_byte_adder_test.sv
module dec_byte_adder_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] src_byte = '0;
   logic [7:0] dst_byte = '0;
   logic       ext_in = 1'b0;
   logic       zero_in = 1'b0;
   logic [7:0] sum_out;
   logic       ext_out, neg_out, zero_out, ovf_out, carry_out, done;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   int exp_sum = 0;
   int exp_c = 0;
   int exp_z = 0;
   int exp_done = 0;

   always #2 clk = ~clk;

   dec_byte_adder uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_byte(src_byte), .dst_byte(dst_byte),
      .ext_in(ext_in), .zero_in(zero_in),
      .sum_out(sum_out), .ext_out(ext_out), .neg_out(neg_out),
      .zero_out(zero_out), .ovf_out(ovf_out), .carry_out(carry_out),
      .done(done)
   );

   // Behavioural reference: decimal addition on integers
   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!rst_n) begin
         exp_sum <= 0; exp_c <= 0; exp_z <= 0; exp_done <= 0;
      end else begin
         exp_done <= int'(start);
         if (start) begin
            int lo, hi, cl, ch, total;
            lo = int'(src_byte % 16) + int'(dst_byte % 16) + int'(ext_in);
            cl = (lo > 9) ? 1 : 0;
            if (cl == 1) lo = lo + 6;
            lo = lo % 16;
            hi = int'(src_byte / 16) + int'(dst_byte / 16) + cl;
            ch = (hi > 9) ? 1 : 0;
            if (ch == 1) hi = hi + 6;
            hi = hi % 16;
            total = hi * 16 + lo;
            exp_sum <= total;
            exp_c   <= ch;
            exp_z   <= (total != 0) ? 0 : int'(zero_in);
         end
      end
   end

   task automatic chk(input string tag, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, expv, cycles);
      end
   endtask

   // Compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 R2 R10 sum_out", int'(sum_out), exp_sum);
         chk("R3 carry_out", int'(carry_out), exp_c);
         chk("R4 ext_out", int'(ext_out), exp_c);
         chk("R5 zero_out", int'(zero_out), exp_z);
         chk("R6 neg_out", int'(neg_out), exp_sum / 128);
         chk("R6 ovf_out", int'(ovf_out), 0);
         chk("R7 done", int'(done), exp_done);
      end
   end

   task automatic op(input logic [7:0] s, input logic [7:0] d, input logic x, input logic z);
      @(negedge clk);
      src_byte = s; dst_byte = d; ext_in = x; zero_in = z; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 sum_out", int'(sum_out), 0);
      chk("R9 flags", int'({ext_out, neg_out, zero_out, ovf_out, carry_out}), 0);
      chk("R9 done", int'(done), 0);
      rst_n = 1'b1;
      op(8'h12, 8'h34, 1'b0, 1'b1);   // no correction: 46
      op(8'h08, 8'h05, 1'b0, 1'b0);   // low-digit fix only: 13
      op(8'h99, 8'h00, 1'b1, 1'b1);   // wrap to 00 carry, Z kept 1
      op(8'h99, 8'h00, 1'b1, 1'b0);   // wrap to 00 carry, Z stays 0
      op(8'h50, 8'h50, 1'b0, 1'b1);   // high-digit fix only: 00 carry
      op(8'hFF, 8'hFF, 1'b1, 1'b0);   // R10: non-decimal nibbles -> 55 carry
      op(8'h45, 8'h45, 1'b0, 1'b1);   // 90, neg bit set
      // R8: idle cycles with changing inputs
      @(negedge clk);
      src_byte = 8'h77; dst_byte = 8'h11; ext_in = 1'b1;
      repeat (4) @(negedge clk);
      // back-to-back starts
      @(negedge clk);
      for (int i = 0; i < 3000; i++) begin
         src_byte = 8'($urandom);
         dst_byte = 8'($urandom);
         if (i % 3 == 0) begin
            src_byte = 8'((i / 10) % 10 * 16 + i % 10);
            dst_byte = 8'(((i / 7) % 10) * 16 + (i / 3) % 10);
         end
         ext_in  = 1'($urandom);
         zero_in = 1'($urandom);
         start   = ($urandom % 4) != 0;
         @(negedge clk);
      end
      start = 1'b0;
      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule